// File: doc/BRIEF.md
# Five-Valued Fault Algebra Evaluator

This block evaluates logic gates over the five values used in single-fault test generation: 0, 1, X (unknown), D and D'. D stands for a line that is 1 in the fault-free circuit and 0 in the faulty one. D' is the opposite case. Each operand is treated internally as a good/faulty pair. Fault effects therefore pass through a gate, or cancel, according to the fault calculus and not by plain Boolean logic. A caller gives a gate kind (AND, OR, NOT, NAND, NOR) and two encoded operands. The block returns the encoded result and a flag that is high when a fault effect reaches the output.

The same clocked request also applies four encoded values to a small fixed netlist of gates. This shows how a fault effect travels through several levels of logic, or is blocked along the way. Both results are registered and appear one cycle after the request. The search side of test generation, such as tracking the frontier or backtracking, belongs to a tool or engine that calls this block.

Top module: `dval_eval_top`

## Requirements
- R1: Values use 3-bit codes: 000=0, 001=1, 010=D, 011=D', 100=X. Any operand code from 101 to 111 is treated as X, and no output ever carries a code above 100.
- R2: An AND with a 0 on either operand gives 0 (code 000), whatever the other operand is, including X, D, D' and unused codes.
- R3: AND with a 1 on one side passes the other operand through unchanged. D AND D gives D, D' AND D' gives D', and D AND D' gives 0.
- R4: An OR with a 1 on either operand gives 1, D OR D' gives 1, and OR with a 0 on one side passes the other operand through.
- R5: X AND 1, X OR 0, and X combined with X, D or D' under AND or OR all give X, unless the other operand is the controlling value (0 for AND, 1 for OR).
- R6: NOT (kind code 010) uses only operand A. It swaps 0 with 1 and D with D', and leaves X as X. NAND (011) and NOR (100) give the NOT of AND (000) and OR (001).
- R7: A gate kind code from 101 to 111 gives X.
- R8: The fault flag beside each result is high exactly when that result is D or D'.
- R9: When a request is accepted (op_valid high at a rising edge), res_valid is high after the next rising edge and both results are updated. When no request is accepted, res_valid goes low and both results hold their values.
- R10: While reset is held, res_valid is 0, both results are X (100) and both fault flags are 0.
- R11: The netlist output is NOR(OR(AND(n0, n1), NOT(n2)), n3). Here n0 is net_in[2:0], n1 is net_in[5:3], n2 is net_in[8:6] and n3 is net_in[11:9].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Request strobe |
| op_kind | input | 3 | Gate kind: 000 AND, 001 OR, 010 NOT, 011 NAND, 100 NOR |
| opnd_a | input | 3 | Encoded operand A |
| opnd_b | input | 3 | Encoded operand B (ignored by NOT) |
| net_in | input | 12 | Four encoded netlist inputs n0..n3, n0 in the low bits |
| res_valid | output | 1 | Results updated by the last request |
| res_code | output | 3 | Encoded gate result |
| res_fault | output | 1 | Gate result is D or D' |
| net_code | output | 3 | Encoded netlist output |
| net_fault | output | 1 | Netlist output is D or D' |

## Verification
The bench tries every gate kind against every pair of the eight operand codes. This finds a design that treats D AND D' as X instead of 0, or that lets X win over a controlling value. It also finds a design that mishandles the unused operand or kind codes, or that lets operand B affect NOT. All 625 combinations of netlist inputs are applied, so a fault effect that is dropped or wrongly inverted along a path gives a wrong output. Idle gaps between requests check that the results hold and that res_valid falls. A design that updated its results without a request would fail these checks.

// File: rtl/dval_pkg.sv
// Shared codes for the five-valued fault algebra.
// Assumes 3-bit value codes; unused codes are read as unknown.
package dval_pkg;
    localparam int CODE_W  = 3;
    localparam int NET_INS = 4;
    localparam int NET_W   = NET_INS * CODE_W;

    localparam logic [CODE_W-1:0] V_ZERO = 3'b000;
    localparam logic [CODE_W-1:0] V_ONE  = 3'b001;
    localparam logic [CODE_W-1:0] V_D    = 3'b010;
    localparam logic [CODE_W-1:0] V_DBAR = 3'b011;
    localparam logic [CODE_W-1:0] V_X    = 3'b100;

    localparam logic [2:0] G_AND  = 3'b000;
    localparam logic [2:0] G_OR   = 3'b001;
    localparam logic [2:0] G_NOT  = 3'b010;
    localparam logic [2:0] G_NAND = 3'b011;
    localparam logic [2:0] G_NOR  = 3'b100;

    // Good/faulty pair; known=0 means the value is unknown.
    typedef struct packed {
        logic known;
        logic good;
        logic bad;
    } pair_t;
endpackage

// File: rtl/dval_gate.sv
// One gate in the five-valued algebra, purely combinational.
// Operands are split into good/faulty pairs, combined per circuit copy,
// then re-encoded. Assumes op codes from dval_pkg; others give X.
module dval_gate
    import dval_pkg::*;
(
    input  logic [2:0]        kind,
    input  logic [CODE_W-1:0] in_a,
    input  logic [CODE_W-1:0] in_b,
    output logic [CODE_W-1:0] out_code,
    output logic              out_fault
);
    // Turn a code into a good/faulty pair; unused codes are unknown.
    function automatic pair_t split(input logic [CODE_W-1:0] c);
        pair_t p;
        case (c)
            V_ZERO:  p = '{known: 1'b1, good: 1'b0, bad: 1'b0};
            V_ONE:   p = '{known: 1'b1, good: 1'b1, bad: 1'b1};
            V_D:     p = '{known: 1'b1, good: 1'b1, bad: 1'b0};
            V_DBAR:  p = '{known: 1'b1, good: 1'b0, bad: 1'b1};
            default: p = '{known: 1'b0, good: 1'b0, bad: 1'b0};
        endcase
        return p;
    endfunction

    pair_t pa, pb, p_and, p_or, p_res;
    logic  a_is0, b_is0, a_is1, b_is1;

    // Classify operands as controlling values.
    always_comb begin
        pa    = split(in_a);
        pb    = split(in_b);
        a_is0 = pa.known & ~pa.good & ~pa.bad;
        b_is0 = pb.known & ~pb.good & ~pb.bad;
        a_is1 = pa.known &  pa.good &  pa.bad;
        b_is1 = pb.known &  pb.good &  pb.bad;
    end

    // AND and OR per circuit copy, with controlling values dominating X.
    always_comb begin
        if (a_is0 | b_is0)
            p_and = '{known: 1'b1, good: 1'b0, bad: 1'b0};
        else if (!pa.known | !pb.known)
            p_and = '{known: 1'b0, good: 1'b0, bad: 1'b0};
        else
            p_and = '{known: 1'b1, good: pa.good & pb.good, bad: pa.bad & pb.bad};

        if (a_is1 | b_is1)
            p_or = '{known: 1'b1, good: 1'b1, bad: 1'b1};
        else if (!pa.known | !pb.known)
            p_or = '{known: 1'b0, good: 1'b0, bad: 1'b0};
        else
            p_or = '{known: 1'b1, good: pa.good | pb.good, bad: pa.bad | pb.bad};
    end

    // Select the gate kind; inversion flips both copies, unknown stays unknown.
    always_comb begin
        case (kind)
            G_AND:   p_res = p_and;
            G_OR:    p_res = p_or;
            G_NOT:   p_res = '{known: pa.known,    good: ~pa.good,    bad: ~pa.bad};
            G_NAND:  p_res = '{known: p_and.known, good: ~p_and.good, bad: ~p_and.bad};
            G_NOR:   p_res = '{known: p_or.known,  good: ~p_or.good,  bad: ~p_or.bad};
            default: p_res = '{known: 1'b0, good: 1'b0, bad: 1'b0};
        endcase
    end

    // Re-encode the pair and raise the flag when the copies differ.
    always_comb begin
        if (!p_res.known)
            out_code = V_X;
        else begin
            case ({p_res.good, p_res.bad})
                2'b00:   out_code = V_ZERO;
                2'b11:   out_code = V_ONE;
                2'b10:   out_code = V_D;
                default: out_code = V_DBAR;
            endcase
        end
        out_fault = p_res.known & (p_res.good ^ p_res.bad);
    end
endmodule

// File: rtl/dval_netlist.sv
// Fixed four-input netlist: y = NOR(OR(AND(n0,n1), NOT(n2)), n3).
// Built from dval_gate instances; assumes n0 sits in the low code slot.
module dval_netlist
    import dval_pkg::*;
(
    input  logic [NET_W-1:0]  n_in,
    output logic [CODE_W-1:0] n_out,
    output logic              n_fault
);
    logic [CODE_W-1:0] node [NET_INS];
    logic [CODE_W-1:0] w_and, w_not, w_or;
    logic              f_and, f_not, f_or;

    // Slice the packed input into per-line codes.
    for (genvar i = 0; i < NET_INS; i++) begin : g_slice
        assign node[i] = n_in[i*CODE_W +: CODE_W];
    end

    dval_gate u_and (.kind(G_AND), .in_a(node[0]), .in_b(node[1]),
                     .out_code(w_and), .out_fault(f_and));
    dval_gate u_not (.kind(G_NOT), .in_a(node[2]), .in_b(V_X),
                     .out_code(w_not), .out_fault(f_not));
    dval_gate u_or  (.kind(G_OR),  .in_a(w_and),   .in_b(w_not),
                     .out_code(w_or),  .out_fault(f_or));
    dval_gate u_nor (.kind(G_NOR), .in_a(w_or),    .in_b(node[3]),
                     .out_code(n_out), .out_fault(n_fault));

    logic unused_flags;
    assign unused_flags = f_and ^ f_not ^ f_or;
endmodule

// File: rtl/dval_eval_top.sv
// Registered five-valued evaluator: one free gate plus the fixed netlist.
// Results appear one cycle after op_valid and hold otherwise.
// Synchronous active-low reset loads X into both results.
module dval_eval_top
    import dval_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [CODE_W-1:0] opnd_a,
    input  logic [CODE_W-1:0] opnd_b,
    input  logic [NET_W-1:0]  net_in,
    output logic              res_valid,
    output logic [CODE_W-1:0] res_code,
    output logic              res_fault,
    output logic [CODE_W-1:0] net_code,
    output logic              net_fault
);
    logic [CODE_W-1:0] g_code, n_code;
    logic              g_fault, n_flt;

    dval_gate u_gate (.kind(op_kind), .in_a(opnd_a), .in_b(opnd_b),
                      .out_code(g_code), .out_fault(g_fault));

    dval_netlist u_net (.n_in(net_in), .n_out(n_code), .n_fault(n_flt));

    // Capture both results on a request, hold them between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_code  <= V_X;
            res_fault <= 1'b0;
            net_code  <= V_X;
            net_fault <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_code  <= g_code;
                res_fault <= g_fault;
                net_code  <= n_code;
                net_fault <= n_flt;
            end
        end
    end
endmodule

// File: rtl/dval_eval_chk.sv
// Property checker for dval_eval_top, attached by bind below.
module dval_eval_chk
    import dval_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_kind,
    input logic [CODE_W-1:0] opnd_a,
    input logic [CODE_W-1:0] opnd_b,
    input logic              res_valid,
    input logic [CODE_W-1:0] res_code,
    input logic              res_fault,
    input logic [CODE_W-1:0] net_code,
    input logic              net_fault
);
    p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_code <= V_X) && (net_code <= V_X));

    p_and_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == G_AND && (opnd_a == V_ZERO || opnd_b == V_ZERO)
        |=> res_code == V_ZERO);

    p_or_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == G_OR && (opnd_a == V_ONE || opnd_b == V_ONE)
        |=> res_code == V_ONE);

    p_not_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == G_NOT && opnd_a == V_D |=> res_code == V_DBAR);

    p_bad_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind > G_NOR |=> res_code == V_X);

    p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault == (res_code == V_D || res_code == V_DBAR));

    p_net_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        net_fault == (net_code == V_D || net_code == V_DBAR));

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid && $stable(res_code) && $stable(net_code));
endmodule

bind dval_eval_top dval_eval_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
    .res_code(res_code), .res_fault(res_fault), .net_code(net_code),
    .net_fault(net_fault)
);

// File: tb/dval_eval_top_bench.sv
// Scoreboard bench: reference model works on sets of good/faulty pairs.
module dval_eval_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [2:0]  opnd_a = '0;
    logic [2:0]  opnd_b = '0;
    logic [11:0] net_in = '0;
    logic        res_valid, res_fault, net_fault;
    logic [2:0]  res_code, net_code;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] a;
        logic [2:0] b;
        logic [2:0] code;
        logic       flag;
        logic [2:0] ncode;
        logic       nflag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dval_eval_top u_dval_eval_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .net_in(net_in),
        .res_valid(res_valid), .res_code(res_code), .res_fault(res_fault),
        .net_code(net_code), .net_fault(net_fault)
    );

    // Set of possible (good,faulty) pairs, bit index = {good,faulty}.
    function automatic logic [3:0] to_set(input logic [2:0] c);
        case (c)
            3'd0:    return 4'b0001;
            3'd1:    return 4'b1000;
            3'd2:    return 4'b0100;
            3'd3:    return 4'b0010;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [2:0] from_set(input logic [3:0] s);
        case (s)
            4'b0001: return 3'd0;
            4'b1000: return 3'd1;
            4'b0100: return 3'd2;
            4'b0010: return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [2:0] ref_gate(input logic [2:0] op, input logic [2:0] a,
                                            input logic [2:0] b);
        logic [3:0] sa, sb2, so;
        sa = to_set(a);
        sb2 = (op == 3'd2) ? 4'b0001 : to_set(b);
        so = '0;
        if (op > 3'd4) return 3'd4;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                if (sa[i] && sb2[j]) begin
                    logic [1:0] r;
                    case (op)
                        3'd0: r = 2'(i) & 2'(j);
                        3'd1: r = 2'(i) | 2'(j);
                        3'd2: r = ~2'(i);
                        3'd3: r = ~(2'(i) & 2'(j));
                        default: r = ~(2'(i) | 2'(j));
                    endcase
                    so[r] = 1'b1;
                end
        return from_set(so);
    endfunction

    function automatic string gate_tag(input logic [2:0] op, input logic [2:0] a,
                                       input logic [2:0] b);
        if (op > 3'd4) return "R7";
        if (a > 3'd4 || (b > 3'd4 && op != 3'd2)) return "R1";
        if (op == 3'd0 && (a == 3'd0 || b == 3'd0)) return "R2";
        if (op == 3'd1 && (a == 3'd1 || b == 3'd1)) return "R4";
        if (a == 3'd4 || (b == 3'd4 && op != 3'd2)) return "R5";
        if (op >= 3'd2) return "R6";
        return (op == 3'd0) ? "R3" : "R4";
    endfunction

    task automatic check(input string req, input string what, input logic [3:0] act,
                         input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: apply one request and push its expected results.
    task automatic drive(input logic [2:0] op, input logic [2:0] a, input logic [2:0] b,
                         input logic [11:0] n);
        exp_t e;
        logic [2:0] p, q, r;
        @(negedge clk);
        op_valid = 1'b1; op_kind = op; opnd_a = a; opnd_b = b; net_in = n;
        e.op = op; e.a = a; e.b = b;
        e.code = ref_gate(op, a, b);
        e.flag = (e.code == 3'd2 || e.code == 3'd3);
        p = ref_gate(3'd0, n[2:0], n[5:3]);
        q = ref_gate(3'd2, n[8:6], 3'd0);
        r = ref_gate(3'd1, p, q);
        e.ncode = ref_gate(3'd4, r, n[11:9]);
        e.nflag = (e.ncode == 3'd2 || e.ncode == 3'd3);
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            op_kind = 3'd1; opnd_a = 3'd1; opnd_b = 3'd1; net_in = 12'hFFF;
        end
    endtask

    // Monitor: compare results one cycle after each request, check hold when idle.
    logic [2:0] last_code = 3'd4, last_ncode = 3'd4;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_valid) begin
                if (sb.size() == 0) begin
                    check("R9", "unexpected res_valid", 4'(res_valid), 4'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(gate_tag(e.op, e.a, e.b), "gate result", 4'(res_code), 4'(e.code));
                    check("R8", "gate fault flag", 4'(res_fault), 4'(e.flag));
                    check("R11", "netlist result", 4'(net_code), 4'(e.ncode));
                    check("R8", "netlist fault flag", 4'(net_fault), 4'(e.nflag));
                end
                last_code = res_code;
                last_ncode = net_code;
            end else begin
                check("R9", "gate result held", 4'(res_code), 4'(last_code));
                check("R9", "netlist result held", 4'(net_code), 4'(last_ncode));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state while reset is held.
        check("R10", "res_valid in reset", 4'(res_valid), 4'd0);
        check("R10", "res_code in reset", 4'(res_code), 4'd4);
        check("R10", "res_fault in reset", 4'(res_fault), 4'd0);
        check("R10", "net_code in reset", 4'(net_code), 4'd4);
        check("R10", "net_fault in reset", 4'(net_fault), 4'd0);
        rst_n = 1'b1;
        idle(2);
        // Every kind against every operand code pair; netlist inputs cycle base 5.
        for (int k = 0; k < 625; k++) begin
            logic [11:0] n;
            int m;
            m = k;
            for (int d = 0; d < 4; d++) begin
                n[d*3 +: 3] = 3'(m % 5);
                m = m / 5;
            end
            drive(3'(k >> 6), 3'(k >> 3), 3'(k), n);
            if (k % 37 == 5) idle(2);
        end
        // R6: operand B must not affect NOT; R1: unused codes read as X.
        drive(3'd2, 3'd2, 3'd0, 12'd0);
        drive(3'd2, 3'd2, 3'd7, 12'd0);
        drive(3'd0, 3'd6, 3'd1, 12'd0);
        drive(3'd1, 3'd0, 3'd5, 12'd0);
        idle(4);
        done = 1;
        check("R9", "all requests answered", 4'(sb.size() != 0), 4'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule